// File: doc/BRIEF.md
# Layer-1 Activation State Machine

This block follows the activation state of an ISDN S-interface terminal. A line transceiver reports its view of the line as a 4-bit indication code qualified by a strobe. Layer 2 can ask for activation through a request input. The block walks the F-state table and answers each step in three ways. It can send a 4-bit command to the transceiver, formatted as a 6-bit control word. It can pulse an activate or a deactivate indication toward layer 2. It also keeps a status output, `linkActive`, that is high only while the link is fully active (F7); neighbouring data-path blocks use it to gate frame transfer.

An activation attempt is supervised by an internal down-counter. If the link has not reached F7 when the counter runs out, the block tells the transceiver to deactivate and tells layer 2 that the attempt failed. The state stays where it is. Reaching F7 stops the counter. Every decision is taken at a clock edge, and all outputs come from registers.

Top module: `l1_activation_fsm`

## Requirements
- R1: While reset is held and after it is released, `l1State` is 0 (RESET), `linkActive`, `cmdValid`, `actInd` and `deactInd` are 0 and `cmdWord` is 0.
- R2: An indication counts as an event only in a cycle where `indStrobe` is high and `indCode` differs from the code of the previous strobe. The first strobe after reset always counts. Repeated codes, codes seen without a strobe, and codes with no transition listed for the current state leave every output unchanged. Indication codes are: DR=0000, RES=0001, RSY=0100, DR6=0101, EI=0110, PU=0111, AR=1000, AI8=1100, DC=1111. All other values have no transition.
- R3: States are encoded on `l1State` as RESET=0, F3 power-down=1, F3 power-up=2, F3 pending-deactivation=3, F4=4, F5=5, F6=6, F7=7, F8=8. The transitions are:
  - DC moves RESET, F3-pending, F4, F5, F6 and F8 to F3 power-down.
  - AR moves RESET, F3 power-down, F3-pending, F5 and F8 to F6.
  - RSY moves F3 power-down, F3-pending and F4 to F5, and moves F6 to F8.
  - PU moves F3 power-down to F4.
  - DR moves F5 and F8 to F3-pending and issues DI. DR6 does the same from F6.
- R4: RES or EI moves any state to RESET and issues DI. When the state was F7, this also pulses `deactInd`.
- R5: AI8 in any state other than F7 and F3 power-up moves to F7, issues AR8, pulses `actInd` and cancels the supervision timer. `actInd` and `deactInd` are never high together.
- R6: Leaving F7 always pulses `deactInd`. AR goes to F6, RSY goes to F8, and DR goes to F3-pending and issues DI.
- R7: `actReq` is acted on only in F3 power-down, and only when `deactReq` is low in the same cycle. It issues AR8 and (re)starts the timer, and the state does not change. `deactReq` alone has no effect.
- R8: A timer started at clock edge E expires at edge E+TIMER_LOAD+1, unless it is cancelled or restarted first. In F3 power-down, F4, F5, F6 or F8, expiry issues DI and pulses `deactInd`, and the state does not change. In other states it has no effect.
- R9: A command appears as a one-cycle `cmdValid` with `cmdWord` = {code, 2'b11}. DI is code 1111, giving 6'h3F. AR8 is code 1000, giving 6'h23. `cmdWord` is 0 whenever `cmdValid` is low.
- R10: When events coincide in one cycle, only the highest-priority event is handled. An indication event comes first, then an accepted activate request, then timer expiry.
- R11: `linkActive` is high exactly when `l1State` is 7.
- R12: Inputs sampled at a clock edge affect the outputs right after that same edge, and pulse outputs last exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| indStrobe | input | 1 | Qualifies `indCode` in this cycle |
| indCode | input | 4 | Line indication code from transceiver |
| actReq | input | 1 | Activate request from layer 2 |
| deactReq | input | 1 | Deactivate request from layer 2 |
| cmdValid | output | 1 | One-cycle command strobe to transceiver |
| cmdWord | output | 6 | Command code shifted left two, low bits 11 |
| actInd | output | 1 | One-cycle activate indication to layer 2 |
| deactInd | output | 1 | One-cycle deactivate indication to layer 2 |
| linkActive | output | 1 | High while in F7 |
| l1State | output | 4 | Current F-state encoding |

## Verification
A directed walk drives the block through every state by the codes that lead there. It shows that each transition raises the correct command and indication, and that the same code arriving from F7 differs from the same code arriving elsewhere. Timer runs are driven with three endings: left to expire, cut off by AI8, and never started because an indication won the same cycle. These separate a correct supervision window from a timer that is off by one, is not cancelled, or ignores priority. Repeated codes, strobe-less code changes and unlisted codes tell edge-qualified detection apart from level detection. A long stretch of random strobes, codes and requests is then compared every cycle against a behavioural model.

// File: rtl/l1act_pkg.sv
`timescale 1ns/1ps
package l1act_pkg;

  typedef enum logic [3:0] {
    ST_RESET   = 4'd0,
    ST_F3_DOWN = 4'd1,
    ST_F3_UP   = 4'd2,
    ST_F3_PEND = 4'd3,
    ST_F4      = 4'd4,
    ST_F5      = 4'd5,
    ST_F6      = 4'd6,
    ST_F7      = 4'd7,
    ST_F8      = 4'd8
  } l1State_e;

  // line indication codes that have transitions
  localparam logic [3:0] IND_DR  = 4'b0000;
  localparam logic [3:0] IND_RES = 4'b0001;
  localparam logic [3:0] IND_RSY = 4'b0100;
  localparam logic [3:0] IND_DR6 = 4'b0101;
  localparam logic [3:0] IND_EI  = 4'b0110;
  localparam logic [3:0] IND_PU  = 4'b0111;
  localparam logic [3:0] IND_AR  = 4'b1000;
  localparam logic [3:0] IND_AI8 = 4'b1100;
  localparam logic [3:0] IND_DC  = 4'b1111;

  // command codes toward the transceiver
  localparam logic [3:0] CMD_DI  = 4'b1111;
  localparam logic [3:0] CMD_AR8 = 4'b1000;
  localparam logic [1:0] CMD_PAD = 2'b11;

  // strobes from control to datapath
  typedef struct packed {
    logic issueDi;
    logic issueAr8;
    logic startTimer;
    logic stopTimer;
  } ctrlStrobe_t;

endpackage

// File: rtl/l1act_datapath.sv
`timescale 1ns/1ps
module l1act_datapath
  import l1act_pkg::*;
#(
  parameter int TIMER_LOAD = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        indStrobe,
  input  logic [3:0]  indCode,
  input  ctrlStrobe_t ctrl,
  output logic        indEvent,
  output logic        timerExpire,
  output logic        cmdValid,
  output logic [5:0]  cmdWord
);

  localparam int CNT_W = $clog2(TIMER_LOAD + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(TIMER_LOAD);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  // strobe-qualified change detection
  logic [3:0] lastCode;
  logic       haveCode;

  assign indEvent = indStrobe && (!haveCode || (indCode != lastCode));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lastCode <= 4'd0;
      haveCode <= 1'b0;
    end else if (indStrobe) begin
      lastCode <= indCode;
      haveCode <= 1'b1;
    end
  end

  // supervision down-counter
  logic [CNT_W-1:0] tmrCount;
  logic             tmrRunning;
  logic             expirePulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmrCount    <= '0;
      tmrRunning  <= 1'b0;
      expirePulse <= 1'b0;
    end else begin
      expirePulse <= 1'b0;
      if (ctrl.startTimer) begin
        tmrRunning <= 1'b1;
        tmrCount   <= LOAD_VAL;
      end else if (ctrl.stopTimer) begin
        tmrRunning <= 1'b0;
      end else if (tmrRunning) begin
        if (tmrCount == CNT_ONE) begin
          tmrRunning  <= 1'b0;
          expirePulse <= 1'b1;
        end
        tmrCount <= tmrCount - CNT_ONE;
      end
    end
  end

  assign timerExpire = expirePulse;

  // command formatter register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdValid <= 1'b0;
      cmdWord  <= '0;
    end else begin
      cmdValid <= ctrl.issueDi | ctrl.issueAr8;
      if (ctrl.issueDi)       cmdWord <= {CMD_DI, CMD_PAD};
      else if (ctrl.issueAr8) cmdWord <= {CMD_AR8, CMD_PAD};
      else                    cmdWord <= '0;
    end
  end

endmodule

// File: rtl/l1act_control.sv
`timescale 1ns/1ps
module l1act_control
  import l1act_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        indEvent,
  input  logic [3:0]  indCode,
  input  logic        actReq,
  input  logic        deactReq,
  input  logic        timerExpire,
  output ctrlStrobe_t ctrl,
  output logic [3:0]  l1State,
  output logic        linkActive,
  output logic        actInd,
  output logic        deactInd
);

  l1State_e state, nextState;
  logic     actNext, deactNext;
  logic     reqAccepted;

  assign reqAccepted = actReq && !deactReq && (state == ST_F3_DOWN);

  always_comb begin
    nextState = state;
    ctrl      = '0;
    actNext   = 1'b0;
    deactNext = 1'b0;
    if (indEvent) begin
      case (indCode)
        IND_RES, IND_EI: begin
          nextState    = ST_RESET;
          ctrl.issueDi = 1'b1;
          deactNext    = (state == ST_F7);
        end
        IND_AI8: begin
          if (state != ST_F7 && state != ST_F3_UP) begin
            nextState      = ST_F7;
            ctrl.issueAr8  = 1'b1;
            ctrl.stopTimer = 1'b1;
            actNext        = 1'b1;
          end
        end
        IND_DC: begin
          if (state inside {ST_RESET, ST_F3_PEND, ST_F4, ST_F5, ST_F6, ST_F8})
            nextState = ST_F3_DOWN;
        end
        IND_AR: begin
          if (state inside {ST_RESET, ST_F3_DOWN, ST_F3_PEND, ST_F5, ST_F8}) begin
            nextState = ST_F6;
          end else if (state == ST_F7) begin
            nextState = ST_F6;
            deactNext = 1'b1;
          end
        end
        IND_RSY: begin
          if (state inside {ST_F3_DOWN, ST_F3_PEND, ST_F4}) begin
            nextState = ST_F5;
          end else if (state == ST_F6) begin
            nextState = ST_F8;
          end else if (state == ST_F7) begin
            nextState = ST_F8;
            deactNext = 1'b1;
          end
        end
        IND_PU: begin
          if (state == ST_F3_DOWN) nextState = ST_F4;
        end
        IND_DR: begin
          if (state inside {ST_F5, ST_F8, ST_F7}) begin
            nextState    = ST_F3_PEND;
            ctrl.issueDi = 1'b1;
            deactNext    = (state == ST_F7);
          end
        end
        IND_DR6: begin
          if (state == ST_F6) begin
            nextState    = ST_F3_PEND;
            ctrl.issueDi = 1'b1;
          end
        end
        default: ;
      endcase
    end else if (reqAccepted) begin
      ctrl.issueAr8   = 1'b1;
      ctrl.startTimer = 1'b1;
    end else if (timerExpire) begin
      if (state inside {ST_F3_DOWN, ST_F4, ST_F5, ST_F6, ST_F8}) begin
        ctrl.issueDi = 1'b1;
        deactNext    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_RESET;
      actInd   <= 1'b0;
      deactInd <= 1'b0;
    end else begin
      state    <= nextState;
      actInd   <= actNext;
      deactInd <= deactNext;
    end
  end

  assign l1State    = state;
  assign linkActive = (state == ST_F7);

endmodule

// File: rtl/l1_activation_fsm.sv
`timescale 1ns/1ps
module l1_activation_fsm
  import l1act_pkg::*;
#(
  parameter int TIMER_LOAD = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       indStrobe,
  input  logic [3:0] indCode,
  input  logic       actReq,
  input  logic       deactReq,
  output logic       cmdValid,
  output logic [5:0] cmdWord,
  output logic       actInd,
  output logic       deactInd,
  output logic       linkActive,
  output logic [3:0] l1State
);

  ctrlStrobe_t ctrl;
  logic        indEvent;
  logic        timerExpire;

  l1act_datapath #(.TIMER_LOAD(TIMER_LOAD)) u_datapath (
    .clk         (clk),
    .rst_n       (rst_n),
    .indStrobe   (indStrobe),
    .indCode     (indCode),
    .ctrl        (ctrl),
    .indEvent    (indEvent),
    .timerExpire (timerExpire),
    .cmdValid    (cmdValid),
    .cmdWord     (cmdWord)
  );

  l1act_control u_control (
    .clk         (clk),
    .rst_n       (rst_n),
    .indEvent    (indEvent),
    .indCode     (indCode),
    .actReq      (actReq),
    .deactReq    (deactReq),
    .timerExpire (timerExpire),
    .ctrl        (ctrl),
    .l1State     (l1State),
    .linkActive  (linkActive),
    .actInd      (actInd),
    .deactInd    (deactInd)
  );

endmodule

// File: rtl/l1act_checker.sv
`timescale 1ns/1ps
module l1act_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       indStrobe,
  input logic       cmdValid,
  input logic [5:0] cmdWord,
  input logic       actInd,
  input logic       deactInd,
  input logic       linkActive,
  input logic [3:0] l1State
);

  assert_ind_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(actInd && deactInd));

  assert_act_enters_f7_R5: assert property (@(posedge clk) disable iff (!rst_n)
    actInd |-> (linkActive && cmdValid && cmdWord == 6'h23));

  assert_leave_f7_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(linkActive) && !linkActive) |-> deactInd);

  assert_cmd_format_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid |-> (cmdWord == 6'h3F || cmdWord == 6'h23));

  assert_cmd_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmdValid |-> (cmdWord == 6'h00));

  assert_no_strobe_no_move_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(indStrobe) |-> $stable(l1State));

  assert_state_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (l1State <= 4'd8) && (l1State != 4'd2));

endmodule

bind l1_activation_fsm l1act_checker u_l1act_checker (.*);

// File: tb/l1_activation_fsm_bench.sv
`timescale 1ns/1ps
module l1_activation_fsm_bench;

  localparam int LOAD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       indStrobe = 1'b0;
  logic [3:0] indCode = 4'd0;
  logic       actReq = 1'b0;
  logic       deactReq = 1'b0;
  logic       cmdValid, actInd, deactInd, linkActive;
  logic [5:0] cmdWord;
  logic [3:0] l1State;

  always #5 clk = ~clk;

  l1_activation_fsm #(.TIMER_LOAD(LOAD)) u_l1_activation_fsm (
    .clk(clk), .rst_n(rst_n), .indStrobe(indStrobe), .indCode(indCode),
    .actReq(actReq), .deactReq(deactReq), .cmdValid(cmdValid),
    .cmdWord(cmdWord), .actInd(actInd), .deactInd(deactInd),
    .linkActive(linkActive), .l1State(l1State)
  );

  int    checks = 0;
  int    errors = 0;
  string curReq = "R3";
  bit    finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int      mState = 0;
  int      mLast = 0;
  bit      mHave = 0;
  longint  cyc = 0;
  longint  deadline = -1;
  bit      eCmdValid = 0, eAct = 0, eDeact = 0;
  int      eCmdWord = 0;

  function automatic bit inSet(int s, int a[$]);
    foreach (a[i]) if (a[i] == s) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mState = 0; mHave = 0; mLast = 0; cyc = 0; deadline = -1;
      eCmdValid = 0; eCmdWord = 0; eAct = 0; eDeact = 0;
    end else begin
      bit ev, expNow;
      int c;
      eCmdValid = 0; eCmdWord = 0; eAct = 0; eDeact = 0;
      c  = int'(indCode);
      ev = indStrobe && (!mHave || c != mLast);
      if (indStrobe) begin mLast = c; mHave = 1; end
      expNow = (deadline == cyc);
      if (expNow) deadline = -1;
      if (ev) begin
        if (c == 1 || c == 6) begin
          eDeact = (mState == 7); mState = 0; eCmdValid = 1; eCmdWord = 'h3F;
        end else if (c == 12) begin
          if (mState != 7 && mState != 2) begin
            mState = 7; eCmdValid = 1; eCmdWord = 'h23; eAct = 1; deadline = -1;
          end
        end else if (c == 15) begin
          if (inSet(mState, '{0, 3, 4, 5, 6, 8})) mState = 1;
        end else if (c == 8) begin
          if (mState == 7) begin mState = 6; eDeact = 1; end
          else if (inSet(mState, '{0, 1, 3, 5, 8})) mState = 6;
        end else if (c == 4) begin
          if (mState == 7) begin mState = 8; eDeact = 1; end
          else if (mState == 6) mState = 8;
          else if (inSet(mState, '{1, 3, 4})) mState = 5;
        end else if (c == 7) begin
          if (mState == 1) mState = 4;
        end else if (c == 0) begin
          if (inSet(mState, '{5, 7, 8})) begin
            eDeact = (mState == 7); mState = 3; eCmdValid = 1; eCmdWord = 'h3F;
          end
        end else if (c == 5) begin
          if (mState == 6) begin mState = 3; eCmdValid = 1; eCmdWord = 'h3F; end
        end
      end else if (actReq && !deactReq && mState == 1) begin
        eCmdValid = 1; eCmdWord = 'h23; deadline = cyc + LOAD + 1;
      end else if (expNow && inSet(mState, '{1, 4, 5, 6, 8})) begin
        eCmdValid = 1; eCmdWord = 'h3F; eDeact = 1;
      end
      cyc++;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit ok;
      ok = (int'(l1State) == mState) && (cmdValid == eCmdValid) &&
           (int'(cmdWord) == eCmdWord) && (actInd == eAct) &&
           (deactInd == eDeact) && (linkActive == (mState == 7));
      chk(ok, curReq, "model compare {state,cmdValid,cmdWord,act,deact,link}",
          {l1State, cmdValid, cmdWord, actInd, deactInd, linkActive},
          {mState[3:0], eCmdValid, eCmdWord[5:0], eAct, eDeact, (mState == 7)});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic sendInd(input logic [3:0] code);
    @(negedge clk); indStrobe = 1'b1; indCode = code;
    @(negedge clk); indStrobe = 1'b0;
  endtask

  task automatic sendAct(input bit withDeact);
    @(negedge clk); actReq = 1'b1; deactReq = withDeact;
    @(negedge clk); actReq = 1'b0; deactReq = 1'b0;
  endtask

  task automatic expectState(input int st, input string req);
    chk(int'(l1State) == st, req, "l1State", l1State, st);
  endtask

  task automatic expectOut(input bit v, input int w, input bit a, input bit d, input string req);
    chk(cmdValid == v && int'(cmdWord) == w, req, "cmdValid/cmdWord",
        {cmdValid, cmdWord}, {v, w[5:0]});
    chk(actInd == a && deactInd == d, req, "actInd/deactInd",
        {actInd, deactInd}, {a, d});
  endtask

  task automatic countDeact(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (deactInd) cnt++;
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    expectState(0, "R1");
    expectOut(0, 0, 0, 0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    expectState(0, "R1");
    chk(linkActive == 0, "R1", "linkActive", linkActive, 0);

    curReq = "R3";
    sendInd(4'hF); expectState(1, "R3");           // DC: RESET -> F3 power-down
    curReq = "R2";
    sendInd(4'hF); expectState(1, "R2");           // repeat ignored
    sendInd(4'h2); expectState(1, "R2");           // TMA has no transition
    expectOut(0, 0, 0, 0, "R2");
    @(negedge clk); indCode = 4'h8;                // change without strobe
    repeat (2) @(negedge clk);
    expectState(1, "R2");

    curReq = "R7";
    sendAct(1); expectOut(0, 0, 0, 0, "R7");       // cancelled by deactReq
    sendAct(0); expectOut(1, 'h23, 0, 0, "R7");    // AR8 = 6'h23 (R9)
    curReq = "R8";
    repeat (LOAD) @(negedge clk);
    chk(deactInd == 0, "R8", "early expiry", deactInd, 0);
    @(negedge clk);
    expectOut(1, 'h3F, 0, 1, "R8");                // DI = 6'h3F (R9)
    expectState(1, "R8");

    sendAct(0);
    sendInd(4'h7); expectState(4, "R3");           // PU -> F4
    countDeact(LOAD + 3, n);
    chk(n == 1, "R8", "expiry in F4 count", n, 1);
    expectState(4, "R8");
    curReq = "R7";
    sendAct(0); expectOut(0, 0, 0, 0, "R7");       // actReq in F4 ignored

    curReq = "R5";
    sendInd(4'h4); expectState(5, "R3");           // RSY -> F5
    sendInd(4'hF); expectState(1, "R3");
    sendAct(0);
    sendInd(4'h4); expectState(5, "R3");
    sendInd(4'hC); expectState(7, "R5");           // AI8 -> F7
    expectOut(1, 'h23, 1, 0, "R5");
    chk(linkActive == 1, "R11", "linkActive in F7", linkActive, 1);
    countDeact(LOAD + 4, n);
    chk(n == 0, "R5", "timer cancelled", n, 0);

    curReq = "R6";
    sendInd(4'h8); expectState(6, "R6"); expectOut(0, 0, 0, 1, "R6");
    chk(linkActive == 0, "R11", "linkActive after F7", linkActive, 0);
    sendInd(4'h4); expectState(8, "R3");
    sendInd(4'hC); expectState(7, "R5");
    sendInd(4'h4); expectState(8, "R6"); expectOut(0, 0, 0, 1, "R6");
    sendInd(4'hC); expectState(7, "R5");
    sendInd(4'h0); expectState(3, "R6"); expectOut(1, 'h3F, 0, 1, "R6");

    curReq = "R3";
    sendInd(4'hF); expectState(1, "R3");
    sendInd(4'h8); expectState(6, "R3");
    sendInd(4'h5); expectState(3, "R3"); expectOut(1, 'h3F, 0, 0, "R3");
    sendInd(4'h4); expectState(5, "R3");
    sendInd(4'h0); expectState(3, "R3"); expectOut(1, 'h3F, 0, 0, "R3");

    curReq = "R4";
    sendInd(4'h8); sendInd(4'hC); expectState(7, "R5");
    sendInd(4'h6); expectState(0, "R4"); expectOut(1, 'h3F, 0, 1, "R4");
    sendInd(4'h1); expectState(0, "R4"); expectOut(1, 'h3F, 0, 0, "R4");

    curReq = "R10";
    sendInd(4'hF); expectState(1, "R10");
    @(negedge clk); actReq = 1'b1; indStrobe = 1'b1; indCode = 4'h7;
    @(negedge clk); actReq = 1'b0; indStrobe = 1'b0;
    expectState(4, "R10"); expectOut(0, 0, 0, 0, "R10");
    countDeact(LOAD + 3, n);
    chk(n == 0, "R10", "no timer after lost request", n, 0);

    // random stretch against the model (R12 timing covered every cycle)
    curReq = "R12";
    for (int i = 0; i < 4000; i++) begin
      int pick;
      @(negedge clk);
      pick = $urandom % 12;
      indStrobe = ($urandom % 3) == 0;
      case (pick)
        0: indCode = 4'h0;  1: indCode = 4'h1;  2: indCode = 4'h4;
        3: indCode = 4'h5;  4: indCode = 4'h6;  5: indCode = 4'h7;
        6: indCode = 4'h8;  7: indCode = 4'hC;  8: indCode = 4'hF;
        9: indCode = 4'hC;  10: indCode = 4'h4; default: indCode = 4'($urandom);
      endcase
      actReq   = ($urandom % 6) == 0;
      deactReq = ($urandom % 16) == 0;
    end
    @(negedge clk); indStrobe = 0; actReq = 0; deactReq = 0;
    repeat (LOAD + 4) @(negedge clk);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule